// File: doc/BRIEF.md
# QPSK/OQPSK Carrier and Timing Error Loop

This block closes the error side of a demodulator's two tracking loops. It takes a stream of half-symbol I/Q samples, two per symbol, qualified by a valid strobe. It keeps a sliding window of the six most recent accepted samples. After every fourth accepted sample it computes two values from that window: a polarity-type carrier phase error and a symbol timing error in the style of the Gardner detector. Each error passes through its own fixed-length latency pipeline and then into a programmable second-order loop filter. The filter outputs are the carrier phase estimate for the NCO and the timing offset estimate for the resampler.

A single mode input selects QPSK or OQPSK. The mode changes which window taps each detector pairs, because in OQPSK the Q arm lags the I arm by half a symbol. Changing the mode, or asserting reset, restarts both loops from a clean state.

Top module: `qpsk_track_loop`

## Requirements
- R1: Reset brings both estimates to 0 and holds both update strobes low.
- R2: Only cycles with `s_valid` high advance the window. An error pair is evaluated once after every fourth accepted sample. The window holds six samples, w0 (oldest, time n-2) through w5 (newest, time n+3). Entries that have been cleared read as zero.
- R3: With `mode_oqpsk`=0 (QPSK), the carrier error is c(w3)+c(w5), where c(k)=Q[k]·sgn(I[k]) − I[k]·sgn(Q[k]).
- R4: With `mode_oqpsk`=1 (OQPSK), the carrier error is Q[w2]·sgn(I[w2]) − I[w3]·sgn(Q[w3]) + Q[w4]·sgn(I[w4]) − I[w5]·sgn(Q[w5]).
- R5: In QPSK, the timing error is (I3−I1)·I2 + (Q3−Q1)·Q2 + (I5−I3)·I4 + (Q5−Q3)·Q4, with indices naming window taps.
- R6: In OQPSK, the timing error is (I2−I0)·I1 + (Q3−Q1)·Q2 + (I4−I2)·I3 + (Q5−Q3)·Q4.
- R7: sgn(x) is +1 for x ≥ 0 and −1 for x < 0, so a zero sample counts as positive.
- R8: Each loop filter, on an error e, updates s ← sat(s+e) and then y ← sat(y + α·e + β·s), using the new s. This realises α/(1−z⁻¹)+β/(1−z⁻¹)². With β=0 the loop is first order. Between updates y holds its value.
- R9: `phase_est` takes its new value, and `phase_upd` pulses for one cycle, exactly 5 clock cycles after the edge that accepts a block's fourth sample.
- R10: `timing_est` takes its new value, and `timing_upd` pulses for one cycle, exactly 7 clock cycles after that same edge.
- R11: Both integrators of both loops saturate at +2^31−1 and −2^31 instead of wrapping.
- R12: On an edge where `mode_oqpsk` differs from its value at the previous edge, the window, the block count, every pending error and both filter states are cleared. Estimates read 0 afterwards, and no update from data before the change ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Half-symbol sample valid |
| s_i | input | 12 | In-phase sample, signed |
| s_q | input | 12 | Quadrature sample, signed |
| mode_oqpsk | input | 1 | 0 = QPSK pairing, 1 = OQPSK pairing |
| alpha_c | input | 18 | Carrier loop proportional coefficient, signed |
| beta_c | input | 18 | Carrier loop integral coefficient, signed |
| alpha_g | input | 18 | Timing loop proportional coefficient, signed |
| beta_g | input | 18 | Timing loop integral coefficient, signed |
| phase_est | output | 32 | Carrier phase estimate, signed |
| phase_upd | output | 1 | One-cycle strobe when phase_est changes |
| timing_est | output | 32 | Timing offset estimate, signed |
| timing_upd | output | 1 | One-cycle strobe when timing_est changes |

## Verification
Each block's carrier result is due 5 edges after the edge that accepts the block's fourth sample, and its timing result is due 7 edges after it. When the driver completes a block, it records that acceptance edge number together with the model's expected estimates. The monitor compares each strobe against the head of its queue, checking both the value and the edge number at which the strobe appeared. After a mode change, the expected queues are emptied. Any strobe that arrives after that point, or any strobe that arrives with no expectation queued, counts as a failure.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic {
    MODE_QPSK  = 1'b0,
    MODE_OQPSK = 1'b1
  } tl_mode_e;

  localparam int WIN_LEN = 6;
  localparam int BLK_LEN = 4;
endpackage

// File: rtl/tl_window.sv
module tl_window
  import tl_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            in_vld,
  input  logic [SMP_W-1:0]                in_i,
  input  logic [SMP_W-1:0]                in_q,
  output logic [WIN_LEN-1:0][SMP_W-1:0]   win_i,
  output logic [WIN_LEN-1:0][SMP_W-1:0]   win_q,
  output logic                            blk
);
  localparam int CNT_W = $clog2(BLK_LEN);

  logic [WIN_LEN-1:0][SMP_W-1:0] wi_q, wi_d, wq_q, wq_d;
  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic                          blk_q, blk_d;

  always_comb begin
    wi_d  = wi_q;
    wq_d  = wq_q;
    cnt_d = cnt_q;
    blk_d = 1'b0;
    if (clr) begin
      wi_d  = '0;
      wq_d  = '0;
      cnt_d = '0;
    end else if (in_vld) begin
      wi_d[WIN_LEN-2:0] = wi_q[WIN_LEN-1:1];
      wq_d[WIN_LEN-2:0] = wq_q[WIN_LEN-1:1];
      wi_d[WIN_LEN-1]   = in_i;
      wq_d[WIN_LEN-1]   = in_q;
      cnt_d             = cnt_q + CNT_W'(1);
      blk_d             = (cnt_q == CNT_W'(BLK_LEN-1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q  <= '0;
      wq_q  <= '0;
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      wi_q  <= wi_d;
      wq_q  <= wq_d;
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign win_i = wi_q;
  assign win_q = wq_q;
  assign blk   = blk_q;
endmodule

// File: rtl/tl_detect.sv
module tl_detect
  import tl_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ERR_W = 2*SMP_W + 3
) (
  input  tl_mode_e                        mode,
  input  logic [WIN_LEN-1:0][SMP_W-1:0]   win_i,
  input  logic [WIN_LEN-1:0][SMP_W-1:0]   win_q,
  output logic signed [ERR_W-1:0]         err_c,
  output logic signed [ERR_W-1:0]         err_g
);
  localparam int PROD_W = 2*SMP_W + 1;

  // multiply x by the polarity of s, zero counting as positive
  function automatic logic signed [SMP_W:0] by_sign(
    input logic signed [SMP_W-1:0] x,
    input logic signed [SMP_W-1:0] s
  );
    logic signed [SMP_W:0] xe;
    xe = (SMP_W+1)'(x);
    return s[SMP_W-1] ? -xe : xe;
  endfunction

  // (late - early) * mid
  function automatic logic signed [PROD_W-1:0] slope(
    input logic signed [SMP_W-1:0] late,
    input logic signed [SMP_W-1:0] early,
    input logic signed [SMP_W-1:0] mid
  );
    logic signed [PROD_W-1:0] d;
    d = PROD_W'(late) - PROD_W'(early);
    return d * PROD_W'(mid);
  endfunction

  logic signed [SMP_W-1:0] ti [WIN_LEN];
  logic signed [SMP_W-1:0] tq [WIN_LEN];

  for (genvar k = 0; k < WIN_LEN; k++) begin : g_tap
    assign ti[k] = $signed(win_i[k]);
    assign tq[k] = $signed(win_q[k]);
  end

  always_comb begin
    if (mode == MODE_OQPSK) begin
      err_c = ERR_W'(by_sign(tq[2], ti[2])) - ERR_W'(by_sign(ti[3], tq[3]))
            + ERR_W'(by_sign(tq[4], ti[4])) - ERR_W'(by_sign(ti[5], tq[5]));
      err_g = ERR_W'(slope(ti[2], ti[0], ti[1])) + ERR_W'(slope(tq[3], tq[1], tq[2]))
            + ERR_W'(slope(ti[4], ti[2], ti[3])) + ERR_W'(slope(tq[5], tq[3], tq[4]));
    end else begin
      err_c = ERR_W'(by_sign(tq[3], ti[3])) - ERR_W'(by_sign(ti[3], tq[3]))
            + ERR_W'(by_sign(tq[5], ti[5])) - ERR_W'(by_sign(ti[5], tq[5]));
      err_g = ERR_W'(slope(ti[3], ti[1], ti[2])) + ERR_W'(slope(tq[3], tq[1], tq[2]))
            + ERR_W'(slope(ti[5], ti[3], ti[4])) + ERR_W'(slope(tq[5], tq[3], tq[4]));
    end
  end
endmodule

// File: rtl/tl_delay.sv
module tl_delay #(
  parameter int DATA_W = 27,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_dat
);
  logic [DEPTH-1:0][DATA_W-1:0] dat_q;
  logic [DEPTH-1:0]             vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic              v_src, v_d;
    logic [DATA_W-1:0] d_src, d_d;

    if (g == 0) begin : g_head
      assign v_src = in_vld;
      assign d_src = in_dat;
    end else begin : g_body
      assign v_src = vld_q[g-1];
      assign d_src = dat_q[g-1];
    end

    always_comb begin
      v_d = clr ? 1'b0 : v_src;
      d_d = dat_q[g];
      if (!clr && v_src) d_d = d_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        dat_q[g] <= '0;
      end else begin
        vld_q[g] <= v_d;
        dat_q[g] <= d_d;
      end
    end
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_dat = dat_q[DEPTH-1];
endmodule

// File: rtl/tl_filter.sv
module tl_filter #(
  parameter int ERR_W  = 27,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     e_vld,
  input  logic signed [ERR_W-1:0]  e,
  input  logic signed [COEF_W-1:0] alpha,
  input  logic signed [COEF_W-1:0] beta,
  output logic signed [ACC_W-1:0]  y,
  output logic                     upd
);
  localparam int WIDE = COEF_W + ACC_W + 2;
  localparam logic signed [WIDE-1:0] HI =
    {{(WIDE-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] LO =
    {{(WIDE-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] clip(input logic signed [WIDE-1:0] v);
    if (v > HI) return HI[ACC_W-1:0];
    if (v < LO) return LO[ACC_W-1:0];
    return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] s_q, s_d, y_q, y_d;
  logic                    upd_q, upd_d;
  logic signed [WIDE-1:0]  s_sum, y_sum;
  logic signed [ACC_W-1:0] s_new;

  always_comb begin
    s_sum = WIDE'(s_q) + WIDE'(e);
    s_new = clip(s_sum);
    y_sum = WIDE'(y_q) + WIDE'(alpha) * WIDE'(e) + WIDE'(beta) * WIDE'(s_new);
    s_d   = s_q;
    y_d   = y_q;
    upd_d = 1'b0;
    if (clr) begin
      s_d = '0;
      y_d = '0;
    end else if (e_vld) begin
      s_d   = s_new;
      y_d   = clip(y_sum);
      upd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      y_q   <= '0;
      upd_q <= 1'b0;
    end else begin
      s_q   <= s_d;
      y_q   <= y_d;
      upd_q <= upd_d;
    end
  end

  assign y   = y_q;
  assign upd = upd_q;
endmodule

// File: rtl/qpsk_track_loop.sv
module qpsk_track_loop
  import tl_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 32,
  parameter int LAT_C  = 5,
  parameter int LAT_G  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic [SMP_W-1:0]         s_i,
  input  logic [SMP_W-1:0]         s_q,
  input  logic                     mode_oqpsk,
  input  logic signed [COEF_W-1:0] alpha_c,
  input  logic signed [COEF_W-1:0] beta_c,
  input  logic signed [COEF_W-1:0] alpha_g,
  input  logic signed [COEF_W-1:0] beta_g,
  output logic signed [ACC_W-1:0]  phase_est,
  output logic                     phase_upd,
  output logic signed [ACC_W-1:0]  timing_est,
  output logic                     timing_upd
);
  localparam int ERR_W = 2*SMP_W + 3;

  tl_mode_e mode_cur, mode_q;
  logic     clr;

  assign mode_cur = tl_mode_e'(mode_oqpsk);
  assign clr      = (mode_cur != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_QPSK;
    else        mode_q <= mode_cur;
  end

  logic [WIN_LEN-1:0][SMP_W-1:0] win_i, win_q;
  logic                          blk;
  logic signed [ERR_W-1:0]       err_c, err_g;

  tl_window #(.SMP_W(SMP_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(s_valid & ~clr),
    .in_i(s_i), .in_q(s_q), .win_i(win_i), .win_q(win_q), .blk(blk)
  );

  tl_detect #(.SMP_W(SMP_W), .ERR_W(ERR_W)) u_det (
    .mode(mode_cur), .win_i(win_i), .win_q(win_q), .err_c(err_c), .err_g(err_g)
  );

  logic                    dc_vld, dg_vld;
  logic [ERR_W-1:0]        dc_dat, dg_dat;

  tl_delay #(.DATA_W(ERR_W), .DEPTH(LAT_C-1)) u_dly_c (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(blk), .in_dat(err_c),
    .out_vld(dc_vld), .out_dat(dc_dat)
  );

  tl_delay #(.DATA_W(ERR_W), .DEPTH(LAT_G-1)) u_dly_g (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(blk), .in_dat(err_g),
    .out_vld(dg_vld), .out_dat(dg_dat)
  );

  tl_filter #(.ERR_W(ERR_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_flt_c (
    .clk(clk), .rst_n(rst_n), .clr(clr), .e_vld(dc_vld), .e($signed(dc_dat)),
    .alpha(alpha_c), .beta(beta_c), .y(phase_est), .upd(phase_upd)
  );

  tl_filter #(.ERR_W(ERR_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_flt_g (
    .clk(clk), .rst_n(rst_n), .clr(clr), .e_vld(dg_vld), .e($signed(dg_dat)),
    .alpha(alpha_g), .beta(beta_g), .y(timing_est), .upd(timing_upd)
  );
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_oqpsk,
  input logic [ACC_W-1:0] phase_est,
  input logic             phase_upd,
  input logic [ACC_W-1:0] timing_est,
  input logic             timing_upd
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2: blocks are at least four accepted samples apart
  p_phase_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |=> !phase_upd);
  p_timing_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timing_upd |=> !timing_upd);

  // R8: estimates move only on their strobe or on a mode change
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !phase_upd && $past(mode_oqpsk) == $past(mode_oqpsk, 2))
      |-> $stable(phase_est));
  p_timing_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !timing_upd && $past(mode_oqpsk) == $past(mode_oqpsk, 2))
      |-> $stable(timing_est));

  // R12: a mode change leaves both estimates at zero
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(mode_oqpsk) != $past(mode_oqpsk, 2))
      |-> (phase_est == '0 && timing_est == '0 && !phase_upd && !timing_upd));
endmodule

bind qpsk_track_loop tl_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_oqpsk(mode_oqpsk),
  .phase_est(phase_est), .phase_upd(phase_upd),
  .timing_est(timing_est), .timing_upd(timing_upd)
);

// File: tb/qpsk_track_loop_test.sv
module qpsk_track_loop_test;
  localparam int  LAT_C = 5;
  localparam int  LAT_G = 7;
  localparam longint HI = 64'sd2147483647;
  localparam longint LO = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid;
  logic [11:0] s_i, s_q;
  logic mode_oqpsk;
  logic signed [17:0] alpha_c, beta_c, alpha_g, beta_g;
  logic signed [31:0] phase_est, timing_est;
  logic phase_upd, timing_upd;

  qpsk_track_loop uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
    .mode_oqpsk(mode_oqpsk), .alpha_c(alpha_c), .beta_c(beta_c),
    .alpha_g(alpha_g), .beta_g(beta_g), .phase_est(phase_est),
    .phase_upd(phase_upd), .timing_est(timing_est), .timing_upd(timing_upd)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  int wi[6], wq[6];
  int cnt = 0;
  bit md = 1'b0;
  longint sc = 0, yc = 0, sg = 0, yg = 0;
  longint qc_v[$], qg_v[$];
  int qc_t[$], qg_t[$];

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      check(1'b0, "watchdog", cyc, 0);
      finish_up();
    end
  end

  function automatic longint sat(longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  function automatic longint sm(int x, int s);
    return (s < 0) ? -longint'(x) : longint'(x);
  endfunction

  function automatic longint sl(int late, int early, int mid);
    return (longint'(late) - longint'(early)) * longint'(mid);
  endfunction

  function automatic void model_clear();
    for (int k = 0; k < 6; k++) begin wi[k] = 0; wq[k] = 0; end
    cnt = 0; sc = 0; yc = 0; sg = 0; yg = 0;
  endfunction

  function automatic void model_block(int acc_cyc);
    longint ec, eg;
    if (!md) begin
      ec = sm(wq[3], wi[3]) - sm(wi[3], wq[3]) + sm(wq[5], wi[5]) - sm(wi[5], wq[5]);
      eg = sl(wi[3], wi[1], wi[2]) + sl(wq[3], wq[1], wq[2])
         + sl(wi[5], wi[3], wi[4]) + sl(wq[5], wq[3], wq[4]);
    end else begin
      ec = sm(wq[2], wi[2]) - sm(wi[3], wq[3]) + sm(wq[4], wi[4]) - sm(wi[5], wq[5]);
      eg = sl(wi[2], wi[0], wi[1]) + sl(wq[3], wq[1], wq[2])
         + sl(wi[4], wi[2], wi[3]) + sl(wq[5], wq[3], wq[4]);
    end
    sc = sat(sc + ec);
    yc = sat(yc + longint'(alpha_c) * ec + longint'(beta_c) * sc);
    sg = sat(sg + eg);
    yg = sat(yg + longint'(alpha_g) * eg + longint'(beta_g) * sg);
    qc_v.push_back(yc); qc_t.push_back(acc_cyc + LAT_C);
    qg_v.push_back(yg); qg_t.push_back(acc_cyc + LAT_G);
  endfunction

  // driver: present one valid sample and update the model
  task automatic send(int i, int q);
    @(negedge clk);
    s_valid = 1'b1;
    s_i = 12'(i);
    s_q = 12'(q);
    for (int k = 0; k < 5; k++) begin wi[k] = wi[k+1]; wq[k] = wq[k+1]; end
    wi[5] = i; wq[5] = q;
    cnt++;
    if (cnt == 4) begin
      cnt = 0;
      model_block(cyc + 1);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0;
      s_i = 12'($urandom);
      s_q = 12'($urandom);
    end
  endtask

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  // monitor: pop and compare expected updates
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_upd) begin
        if (qc_v.size() == 0) check(1'b0, {tag, " R9 unexpected phase_upd"}, phase_est, 0);
        else begin
          longint ev; int et;
          ev = qc_v.pop_front(); et = qc_t.pop_front();
          check(phase_est == ev, {tag, " R8 phase_est"}, phase_est, ev);
          check(cyc == et, {tag, " R9 phase latency"}, cyc, et);
        end
      end
      if (timing_upd) begin
        if (qg_v.size() == 0) check(1'b0, {tag, " R10 unexpected timing_upd"}, timing_est, 0);
        else begin
          longint ev; int et;
          ev = qg_v.pop_front(); et = qg_t.pop_front();
          check(timing_est == ev, {tag, " R8 timing_est"}, timing_est, ev);
          check(cyc == et, {tag, " R10 timing latency"}, cyc, et);
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_i = '0; s_q = '0; mode_oqpsk = 1'b0;
    alpha_c = 18'sd5; beta_c = 18'sd0; alpha_g = -18'sd2; beta_g = 18'sd0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(phase_est == 0, "R1 phase_est", phase_est, 0);
    check(timing_est == 0, "R1 timing_est", timing_est, 0);
    check(!phase_upd && !timing_upd, "R1 strobes", {phase_upd, timing_upd}, 0);

    // R3 R5: QPSK, back-to-back random samples
    tag = "R3/R5";
    for (int k = 0; k < 32; k++) send(rnd(), rnd());
    idle(10);

    // R2: gaps between samples with junk data on invalid cycles
    tag = "R2";
    for (int k = 0; k < 16; k++) begin
      send(rnd(), rnd());
      idle(k % 3);
    end
    idle(10);

    // R8: second-order filter with beta active
    tag = "R8";
    alpha_c = -18'sd7; beta_c = 18'sd3; alpha_g = 18'sd1; beta_g = -18'sd2;
    for (int k = 0; k < 24; k++) send(rnd(), rnd());
    idle(10);

    // R7: zero samples count as positive polarity (QPSK)
    tag = "R7";
    send(0, 5); send(-3, 0); send(0, 0); send(7, -1);
    send(0, -9); send(-4, 0); send(0, 0); send(0, 11);
    idle(10);

    // R12: mode change with no pending work clears filters
    tag = "R12";
    mode_oqpsk = 1'b1; md = 1'b1; model_clear();
    @(negedge clk);
    check(phase_est == 0, "R12 phase_est after mode change", phase_est, 0);
    check(timing_est == 0, "R12 timing_est after mode change", timing_est, 0);

    // R4 R6: OQPSK pairing
    tag = "R4/R6";
    for (int k = 0; k < 32; k++) send(rnd(), rnd());
    idle(10);

    tag = "R7";
    send(0, 5); send(-3, 0); send(0, 0); send(7, -1);
    send(0, -9); send(-4, 0); send(0, 0); send(0, 11);
    idle(10);

    // R11: large gains drive carrier to +rail and timing to -rail (OQPSK)
    tag = "R11";
    alpha_c = 18'sd131071; beta_c = 18'sd131071;
    alpha_g = 18'sd131071; beta_g = 18'sd131071;
    for (int k = 0; k < 40; k++) begin
      int a;
      a = ((k % 4) < 2) ? 2000 : -2000;
      send(a, -a / 2);
    end
    idle(10);
    check(phase_est == 32'sh7fffffff, "R11 phase rail", phase_est, HI);
    check(timing_est == 32'sh80000000, "R11 timing rail", timing_est, LO);

    // R12: mode change while updates are still in flight
    tag = "R12";
    alpha_c = 18'sd3; beta_c = 18'sd0; alpha_g = 18'sd1; beta_g = 18'sd0;
    for (int k = 0; k < 4; k++) send(rnd(), rnd());
    @(negedge clk);
    s_valid = 1'b0;
    mode_oqpsk = 1'b0; md = 1'b0; model_clear();
    qc_v.delete(); qc_t.delete(); qg_v.delete(); qg_t.delete();
    idle(10);
    check(phase_est == 0, "R12 phase_est pending dropped", phase_est, 0);
    check(timing_est == 0, "R12 timing_est pending dropped", timing_est, 0);

    tag = "R3/R5";
    for (int k = 0; k < 12; k++) send(rnd(), rnd());
    idle(12);

    check(qc_v.size() == 0, "R9 phase updates outstanding", qc_v.size(), 0);
    check(qg_v.size() == 0, "R10 timing updates outstanding", qg_v.size(), 0);
    finish_up();
  end
endmodule